// File: doc/BRIEF.md
# Crystal Clock Frequency Window Monitor

This block watches a fast external crystal clock from the domain of a slower, trusted reference clock. It makes two judgements. The first is a frequency check: the monitor counts the crystal's rising edges over a fixed number of reference cycles, giving an 11-bit figure. It then compares that figure against a programmable lower and upper bound. The second is a liveness check: if no crystal edge arrives for a set number of reference cycles, the clock is taken as stopped.

Each check has its own run enable and its own interrupt enable. Each check owns a sticky flag that software clears by writing a one to it. The single interrupt line is high while any flag is set together with its interrupt enable. A small word-wide register port carries the bounds, the enables and the flags. The crystal clock is moved into the reference domain by a toggle flop and a synchronizer chain before its edges are counted. For this to work, the crystal must run below half the reference rate.

Top module: `clk_window_monitor`

## Requirements
- R1: After reset every register reads 0 and irqOut is low.
- R2: With the range check enabled (control bit 0 at address 0), the edge count of each window of WIN_CYCLES reference cycles sets the range flag (status bit 0 at address 1) when it exceeds the upper bound held at address 2.
- R3: The range flag is also set when a window count is below the lower bound held at address 3.
- R4: A window count equal to either bound, or between them, leaves the range flag clear.
- R5: With the stop check enabled (control bit 2), the stop flag (status bit 1) is set once STOP_CYCLES reference cycles pass without a synchronized crystal edge. A clock whose gaps between edges are at most STOP_CYCLES cycles leaves it clear.
- R6: Writing 1 to a status bit clears that flag. Writing 0 to a status bit leaves it unchanged.
- R7: irqOut is high exactly when the range flag and the range interrupt enable (control bit 1) are both set, or when the stop flag and the stop interrupt enable (control bit 3) are both set.
- R8: A disabled check holds its counters at zero and never sets its flag, whatever the crystal clock does.
- R9: Control bits [3:0] and the 11-bit bounds at bits [10:0] read back as written. Wider bits of those registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| monClk | input | 1 | Crystal clock under observation |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 status, 2 upper bound, 3 lower bound |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr |
| irqOut | output | 1 | Interrupt request |

## Verification
The edge count is only exact when every window holds a whole number of crystal periods. Otherwise the count wanders by one edge between windows, and a bound placed right at the count gives no fixed answer. The bench therefore produces the crystal clock itself, at periods that divide the window length and with edges kept one nanosecond off the reference edges. This fixes each window's count at WIN_CYCLES divided by the period. For every such period, the bench places the bounds exactly at, one below and one above that count. The stop threshold is approached the same way, with one period equal to the threshold and one period twice as long.

// File: rtl/clk_win_pkg.sv
package clk_win_pkg;

  localparam int CNT_W = 11;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_UPPER = 2'd2;
  localparam logic [1:0] ADDR_LOWER = 2'd3;

  // control to datapath
  typedef struct packed {
    logic rangeRun;
    logic stopRun;
  } monStrobes_t;

  // datapath to control
  typedef struct packed {
    logic             winDone;
    logic [CNT_W-1:0] winCount;
    logic             stopHit;
  } monReport_t;

endpackage

// File: rtl/clk_win_datapath.sv
module clk_win_datapath
  import clk_win_pkg::*;
#(
  parameter int WIN_CYCLES  = 256,
  parameter int STOP_CYCLES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        monClk,
  input  monStrobes_t strobes,
  output monReport_t  report
);

  localparam int WIN_W  = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int STOP_W = $clog2(STOP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
  localparam logic [STOP_W-1:0] STOP_LIM = STOP_W'(STOP_CYCLES);

  // Monitored-domain toggle, one flip per rising edge
  logic monToggle;
  always_ff @(posedge monClk or negedge rst_n) begin
    if (!rst_n) monToggle <= 1'b0;
    else        monToggle <= ~monToggle;
  end

  // Synchronizer chain plus one history stage
  logic [SYNC_STAGES:0] syncChain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncChain <= '0;
    else        syncChain <= {syncChain[SYNC_STAGES-1:0], monToggle};
  end

  logic edgePulse;
  assign edgePulse = syncChain[SYNC_STAGES] ^ syncChain[SYNC_STAGES-1];

  // Window measurement
  logic [WIN_W-1:0] winCnt;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] edgeNext;
  logic             winLast;

  assign winLast  = (winCnt == WIN_LAST);
  assign edgeNext = (edgePulse && edgeCnt != CNT_MAX) ? edgeCnt + 1'b1 : edgeCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCnt  <= '0;
      edgeCnt <= '0;
    end else if (!strobes.rangeRun || winLast) begin
      winCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      winCnt  <= winCnt + 1'b1;
      edgeCnt <= edgeNext;
    end
  end

  // Stop detection
  logic [STOP_W-1:0] stopCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stopCnt <= '0;
    else if (!strobes.stopRun) stopCnt <= '0;
    else if (edgePulse)        stopCnt <= '0;
    else if (stopCnt != STOP_LIM) stopCnt <= stopCnt + 1'b1;
  end

  generate
    if (WIN_CYCLES > 1) begin : g_multiWin
      assign report.winDone = strobes.rangeRun && winLast;
    end else begin : g_singleWin
      assign report.winDone = strobes.rangeRun;
    end
  endgenerate

  assign report.winCount = edgeNext;
  assign report.stopHit  = strobes.stopRun && (stopCnt == STOP_LIM);

  AST_EDGE_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.rangeRun |=> (edgeCnt == '0 && winCnt == '0)); // R8
  AST_STOP_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.stopRun |=> !report.stopHit); // R8
  AST_STOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.stopRun && edgePulse) |=> !report.stopHit); // R5
  AST_WIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (report.winDone && WIN_CYCLES > 1) |=> !report.winDone); // R2

endmodule

// File: rtl/clk_win_ctrl.sv
module clk_win_ctrl
  import clk_win_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  monReport_t        report,
  output monStrobes_t       strobes,
  output logic              irqOut
);

  logic             rangeEn, rangeIrqEn, stopEn, stopIrqEn;
  logic [CNT_W-1:0] upperBd, lowerBd;
  logic             rangeFlag, stopFlag;

  logic wrCtrl, wrStat, wrUpper, wrLower;
  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStat  = regWrEn && (regAddr == ADDR_STAT);
  assign wrUpper = regWrEn && (regAddr == ADDR_UPPER);
  assign wrLower = regWrEn && (regAddr == ADDR_LOWER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rangeEn    <= 1'b0;
      rangeIrqEn <= 1'b0;
      stopEn     <= 1'b0;
      stopIrqEn  <= 1'b0;
    end else if (wrCtrl) begin
      rangeEn    <= regWrData[0];
      rangeIrqEn <= regWrData[1];
      stopEn     <= regWrData[2];
      stopIrqEn  <= regWrData[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upperBd <= '0;
      lowerBd <= '0;
    end else begin
      if (wrUpper) upperBd <= regWrData[CNT_W-1:0];
      if (wrLower) lowerBd <= regWrData[CNT_W-1:0];
    end
  end

  logic rangeSet, stopSet;
  assign rangeSet = report.winDone &&
                    ((report.winCount > upperBd) || (report.winCount < lowerBd));
  assign stopSet  = report.stopHit;

  // Set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rangeFlag <= 1'b0;
      stopFlag  <= 1'b0;
    end else begin
      if (rangeSet)                       rangeFlag <= 1'b1;
      else if (wrStat && regWrData[0])    rangeFlag <= 1'b0;
      if (stopSet)                        stopFlag  <= 1'b1;
      else if (wrStat && regWrData[1])    stopFlag  <= 1'b0;
    end
  end

  assign strobes.rangeRun = rangeEn;
  assign strobes.stopRun  = stopEn;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTRL:  regRdData[3:0] = {stopIrqEn, stopEn, rangeIrqEn, rangeEn};
      ADDR_STAT:  regRdData[1:0] = {stopFlag, rangeFlag};
      ADDR_UPPER: regRdData[CNT_W-1:0] = upperBd;
      ADDR_LOWER: regRdData[CNT_W-1:0] = lowerBd;
      default:    regRdData = '0;
    endcase
  end

  assign irqOut = (rangeFlag && rangeIrqEn) || (stopFlag && stopIrqEn);

  AST_RANGE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rangeFlag) |-> $past(rangeEn)); // R8
  AST_STOP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopFlag) |-> $past(stopEn)); // R8
  AST_RANGE_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rangeFlag) |-> $past(report.winDone)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (rangeFlag || stopFlag)); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rangeFlag && !(wrStat && regWrData[0])) |=> rangeFlag); // R6

endmodule

// File: rtl/clk_window_monitor.sv
module clk_window_monitor
  import clk_win_pkg::*;
#(
  parameter int WIN_CYCLES  = 256,
  parameter int STOP_CYCLES = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              monClk,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);

  monStrobes_t strobes;
  monReport_t  report;

  clk_win_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .report    (report),
    .strobes   (strobes),
    .irqOut    (irqOut)
  );

  clk_win_datapath #(
    .WIN_CYCLES  (WIN_CYCLES),
    .STOP_CYCLES (STOP_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .monClk  (monClk),
    .strobes (strobes),
    .report  (report)
  );

endmodule

// File: tb/clk_window_monitor_tb.sv
module clk_window_monitor_tb_top;

  localparam int WIN  = 64;
  localparam int STOP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        monClk = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd1;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  int monPeriod = 8;
  bit monRun = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  clk_window_monitor #(.WIN_CYCLES(WIN), .STOP_CYCLES(STOP), .SYNC_STAGES(2), .DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .monClk(monClk), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // crystal model: period of monPeriod reference cycles, edges 1 ns off clk edges
  initial begin
    #1;
    forever begin
      if (monRun) begin
        monClk = 1'b1; #(monPeriod * 2);
        monClk = 1'b0; #(monPeriod * 2);
      end else begin
        monClk = 1'b0; #4;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, output int d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = int'(regRdData);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int v;
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(2);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(2'(a), v);
      chk("R1 reset register", v, 0);
    end
    #1 chk("R1 reset irq", int'(irqOut), 0);

    // R9 read-back and field widths
    wrReg(2'd2, 16'hFFFF);
    rdReg(2'd2, v); chk("R9 upper width", v, 16'h07FF);
    wrReg(2'd3, 16'h0555);
    rdReg(2'd3, v); chk("R9 lower value", v, 16'h0555);
    wrReg(2'd0, 16'hFFFA);
    rdReg(2'd0, v); chk("R9 control bits", v, 16'h000A);
    wrReg(2'd0, 16'h0000);
    rdReg(2'd0, v); chk("R9 control cleared", v, 0);

    // R2 R3 R4 sweep over periods and bounds
    monRun = 1'b1;
    for (int p = 2; p <= 64; p = p * 2) begin
      int c;
      monPeriod = p;
      c = WIN / p;
      waitCyc(2 * WIN);
      for (int k = 0; k < 3; k++) begin
        int lo, up, expFlag;
        case (k)
          0: begin lo = c;     up = c;     end
          1: begin lo = 0;     up = c - 1; end
          default: begin lo = c + 1; up = 2047; end
        endcase
        expFlag = ((c > up) || (c < lo)) ? 1 : 0;
        wrReg(2'd0, 16'h0000);
        wrReg(2'd2, 16'(up));
        wrReg(2'd3, 16'(lo));
        wrReg(2'd1, 16'h0003);
        wrReg(2'd0, 16'h0001);
        waitCyc(3 * WIN + 4);
        rdReg(2'd1, v);
        if (k == 0)      chk("R4 count at both bounds", v & 1, expFlag);
        else if (k == 1) chk("R2 count above upper", v & 1, expFlag);
        else             chk("R3 count below lower", v & 1, expFlag);
      end
    end

    // R7 range flag is set now (last case), irq gated by enable
    wrReg(2'd0, 16'h0000);
    #1 chk("R7 irq masked", int'(irqOut), 0);
    wrReg(2'd0, 16'h0002);
    #1 chk("R7 range irq", int'(irqOut), 1);
    // R6 write 0 keeps, write 1 clears
    wrReg(2'd1, 16'h0000);
    rdReg(2'd1, v); chk("R6 write zero keeps", v & 1, 1);
    wrReg(2'd1, 16'h0001);
    rdReg(2'd1, v); chk("R6 write one clears", v & 1, 0);
    #1 chk("R7 irq after clear", int'(irqOut), 0);

    // R8 range disabled with bounds that would fail
    monPeriod = 4;
    wrReg(2'd2, 16'h0000);
    wrReg(2'd3, 16'h07FF);
    wrReg(2'd0, 16'h0002);
    waitCyc(4 * WIN);
    rdReg(2'd1, v); chk("R8 disabled range no flag", v & 1, 0);
    #1 chk("R8 irq stays low", int'(irqOut), 0);

    // R5 stop check
    monPeriod = 8;
    waitCyc(40);
    wrReg(2'd0, 16'h0004);
    waitCyc(100);
    rdReg(2'd1, v); chk("R5 running clock no stop", (v >> 1) & 1, 0);
    monPeriod = STOP;
    waitCyc(2 * STOP);
    wrReg(2'd1, 16'h0002);
    waitCyc(100);
    rdReg(2'd1, v); chk("R5 gap equal threshold no stop", (v >> 1) & 1, 0);
    monPeriod = 2 * STOP;
    waitCyc(150);
    rdReg(2'd1, v); chk("R5 long gap sets stop", (v >> 1) & 1, 1);
    #1 chk("R7 stop masked", int'(irqOut), 0);
    wrReg(2'd0, 16'h000C);
    #1 chk("R7 stop irq", int'(irqOut), 1);

    // R8 stop disabled with dead clock
    wrReg(2'd0, 16'h0000);
    wrReg(2'd1, 16'h0002);
    rdReg(2'd1, v); chk("R6 stop flag cleared", (v >> 1) & 1, 0);
    monRun = 1'b0;
    waitCyc(100);
    rdReg(2'd1, v); chk("R8 disabled stop no flag", (v >> 1) & 1, 0);
    wrReg(2'd0, 16'h0004);
    waitCyc(STOP + 8);
    rdReg(2'd1, v); chk("R5 dead clock sets stop", (v >> 1) & 1, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule